// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block keeps a small stack of nested loop contexts beside the instruction fetch path, so that counted loops need no branch instruction. Each context holds a first-instruction address, a last-instruction address, an iteration count and the current iteration index. The fetch stage gives the block the address of the instruction issuing this cycle. When that address is the last instruction of the innermost loop and more iterations remain, the block sends fetch back to the loop's first instruction in the same cycle.

Three single-cycle commands act on the stack. Loop-begin pushes a new context with its index at zero. Continue starts the next iteration of the innermost loop at once. Break leaves the innermost loop and sends fetch to the address just after its last instruction. The innermost iteration index goes to the datapath. An error strobe reports a push onto a full stack, or a continue or break issued with no loop active.

Top module: `hw_loop_ctrl`

## Requirements
- R1: After reset no loop is active: `idx_o` is 0, `redir_vld` is 0 and `err` is 0.
- R2: A loop-begin that is carried out pushes a context (first address, last address, count). From the next cycle that context is the innermost one and `idx_o` reads 0.
- R3: If `pc` equals the innermost last address, no command is asserted and iterations remain, then `redir_vld` is 1 and `redir_pc` is the first address in that same cycle. The index goes up by one from the next cycle.
- R4: If `pc` equals the innermost last address on the final iteration, no redirect is raised and the context is popped. From the next cycle `idx_o` shows the enclosing loop's index, or 0 when no loop is left.
- R5: Continue on a non-final iteration raises `redir_vld` with `redir_pc` equal to the first address, and the index goes up by one.
- R6: Continue on the final iteration pops the context and redirects to the last address + 1.
- R7: Break pops the innermost context and redirects to its last address + 1, whatever the index is.
- R8: Only the innermost context is examined. A `pc` that matches an outer loop's last address causes no redirect, and outer contexts are kept unchanged while inner loops run.
- R9: A loop-begin while DEPTH contexts are held raises `err` in that cycle and leaves the stack unchanged.
- R10: Continue or break with no active loop raises `err`, gives no redirect and changes nothing.
- R11: When commands are asserted together, break wins over continue and continue wins over loop-begin; the losing commands are dropped. In any cycle with a command asserted, the last-address check is skipped.
- R12: An iteration is the final one when index + 1 >= count, so counts 0 and 1 both run the body once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | AW | Address of the instruction issuing this cycle |
| begin_en | input | 1 | Loop-begin command |
| begin_start | input | AW | First instruction address of the new loop |
| begin_end | input | AW | Last instruction address of the new loop |
| begin_count | input | CW | Iteration count of the new loop |
| cont_en | input | 1 | Continue command |
| brk_en | input | 1 | Break command |
| redir_vld | output | 1 | Fetch must go to `redir_pc` next |
| redir_pc | output | AW | Redirect target |
| idx_o | output | CW | Innermost iteration index |
| err | output | 1 | Stack overflow or command with no active loop |

## Verification
Directed sequences separate the three ways an iteration can end: a loop-back at the last address, a continue, and a break. Each is run on both a non-final and a final iteration, so a wrong last-iteration compare shows up as a redirect missing or appearing where it should not. Nested loops that share or cross addresses show whether only the innermost context is examined. Filling the stack, and issuing commands with no loop active, exercise the error strobe and show that the ignored command left no trace. Random command mixes, with `pc` often steered onto the innermost last address, are checked against a reference stack kept in the bench. These runs expose mistakes in command priority and in index bookkeeping that only appear after long chains of pushes and pops.

// File: rtl/hw_loop_ctrl.sv
module hw_loop_ctrl #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  input  logic          begin_en,
  input  logic [AW-1:0] begin_start,
  input  logic [AW-1:0] begin_end,
  input  logic [CW-1:0] begin_count,
  input  logic          cont_en,
  input  logic          brk_en,
  output logic          redir_vld,
  output logic [AW-1:0] redir_pc,
  output logic [CW-1:0] idx_o,
  output logic          err
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]  st_q  [DEPTH];
  logic [AW-1:0]  en_q  [DEPTH];
  logic [CW-1:0]  cnt_q [DEPTH];
  logic [CW-1:0]  idx_q [DEPTH];
  logic [SPW-1:0] sp_q;

  logic          active, full, last;
  logic [IW-1:0] top, slot;
  logic          do_brk, do_cont, do_push, at_end, wrap, pop;

  assign active = (sp_q != '0);
  assign full   = (sp_q == SPW'(DEPTH));
  assign top    = active ? IW'(sp_q - 1'b1) : '0;
  assign slot   = IW'(sp_q);
  assign last   = ({1'b0, idx_q[top]} + (CW+1)'(1)) >= {1'b0, cnt_q[top]};

  assign do_brk  = brk_en & active;
  assign do_cont = cont_en & ~brk_en & active;
  assign do_push = begin_en & ~brk_en & ~cont_en & ~full;
  assign at_end  = active & ~brk_en & ~cont_en & ~begin_en & (pc == en_q[top]);
  assign wrap    = (at_end | do_cont) & ~last;
  assign pop     = do_brk | ((at_end | do_cont) & last);

  assign redir_vld = wrap | do_brk | (do_cont & last);
  assign redir_pc  = wrap ? st_q[top] : en_q[top] + AW'(1);
  assign idx_o     = active ? idx_q[top] : '0;
  assign err       = (begin_en & ~brk_en & ~cont_en & full) | ((brk_en | cont_en) & ~active);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]  <= '0;
        en_q[i]  <= '0;
        cnt_q[i] <= '0;
        idx_q[i] <= '0;
      end
    end else if (do_push) begin
      st_q[slot]  <= begin_start;
      en_q[slot]  <= begin_end;
      cnt_q[slot] <= begin_count;
      idx_q[slot] <= '0;
      sp_q        <= sp_q + 1'b1;
    end else if (pop) begin
      sp_q <= sp_q - 1'b1;
    end else if (wrap) begin
      idx_q[top] <= idx_q[top] + CW'(1);
    end
  end

  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(DEPTH)); // R9
  AST_IDLE_NO_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !redir_vld); // R10
  AST_PUSH_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_en && !brk_en && !cont_en && !full) |=> (idx_o == '0)); // R2
  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_vld && redir_pc == st_q[top] && !brk_en) |=> (idx_o == $past(idx_o) + CW'(1))); // R3
  AST_BRK_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_en && active) |=> (sp_q == $past(sp_q) - 1'b1)); // R7
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (sp_q == $past(sp_q))); // R9
endmodule

// File: tb/tb_hw_loop_ctrl.sv
module tb_hw_loop_ctrl;
  localparam int AW = 16, CW = 16, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] pc = 0, begin_start = 0, begin_end = 0;
  logic [CW-1:0] begin_count = 0;
  logic begin_en = 0, cont_en = 0, brk_en = 0;
  logic redir_vld, err;
  logic [AW-1:0] redir_pc;
  logic [CW-1:0] idx_o;

  always #2 clk = ~clk;

  hw_loop_ctrl #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .begin_en(begin_en), .begin_start(begin_start),
    .begin_end(begin_end), .begin_count(begin_count), .cont_en(cont_en), .brk_en(brk_en),
    .redir_vld(redir_vld), .redir_pc(redir_pc), .idx_o(idx_o), .err(err));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_sp = 0;
  logic [AW-1:0] m_st [DEPTH];
  logic [AW-1:0] m_en [DEPTH];
  logic [CW-1:0] m_cnt [DEPTH];
  logic [CW-1:0] m_idx [DEPTH];

  function automatic bit m_last();
    return (int'(m_idx[m_sp-1]) + 1) >= int'(m_cnt[m_sp-1]);
  endfunction

  function automatic logic [AW-1:0] m_top_end();
    return (m_sp > 0) ? m_en[m_sp-1] : '0;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [AW-1:0] p, bit b, logic [AW-1:0] s, logic [AW-1:0] e,
                      logic [CW-1:0] c, bit co, bit br);
    bit ev, ee, act_end, wr, pp, ps;
    logic [AW-1:0] ep;
    logic [CW-1:0] ei;
    @(negedge clk);
    pc = p; begin_en = b; begin_start = s; begin_end = e; begin_count = c;
    cont_en = co; brk_en = br;
    #1;
    ev = 0; ep = '0; ee = 0; wr = 0; pp = 0; ps = 0;
    ei = (m_sp > 0) ? m_idx[m_sp-1] : '0;
    if (br || co) begin
      if (m_sp == 0) ee = 1;
      else if (br) begin ev = 1; ep = m_en[m_sp-1] + 1; pp = 1; end
      else if (m_last()) begin ev = 1; ep = m_en[m_sp-1] + 1; pp = 1; end
      else begin ev = 1; ep = m_st[m_sp-1]; wr = 1; end
    end else if (b) begin
      if (m_sp == DEPTH) ee = 1; else ps = 1;
    end else begin
      act_end = (m_sp > 0) && (p == m_en[m_sp-1]);
      if (act_end) begin
        if (m_last()) pp = 1;
        else begin ev = 1; ep = m_st[m_sp-1]; wr = 1; end
      end
    end
    cmp(tag, "redir_vld", 32'(redir_vld), 32'(ev));
    if (ev) cmp(tag, "redir_pc", 32'(redir_pc), 32'(ep));
    cmp(tag, "idx_o", 32'(idx_o), 32'(ei));
    cmp(tag, "err", 32'(err), 32'(ee));
    @(posedge clk);
    if (ps) begin
      m_st[m_sp] = s; m_en[m_sp] = e; m_cnt[m_sp] = c; m_idx[m_sp] = '0; m_sp++;
    end else if (pp) m_sp--;
    else if (wr) m_idx[m_sp-1] = m_idx[m_sp-1] + 1;
  endtask

  task automatic idle(string tag, logic [AW-1:0] p);
    step(tag, p, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit co, br, b;
    logic [AW-1:0] s, p;
    int r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    idle("R1", 16'h0100);
    step("R10", 5, 0, 0, 0, 0, 0, 1);
    step("R10", 5, 0, 0, 0, 0, 1, 0);
    step("R2", 9, 1, 10, 13, 3, 0, 0);
    idle("R2", 10);
    idle("R3", 13);
    step("R5", 11, 0, 0, 0, 0, 1, 0);
    idle("R4", 13);
    idle("R4", 14);
    step("R8", 19, 1, 20, 40, 5, 0, 0);
    idle("R3", 40);
    step("R8", 21, 1, 22, 25, 2, 0, 0);
    idle("R8", 40);
    idle("R8", 25);
    idle("R4", 25);
    idle("R8", 26);
    step("R2", 27, 1, 30, 31, 9, 0, 0);
    step("R2", 30, 1, 31, 31, 9, 0, 0);
    step("R2", 31, 1, 32, 33, 9, 0, 0);
    step("R9", 32, 1, 50, 60, 2, 0, 0);
    idle("R9", 60);
    step("R7", 32, 0, 0, 0, 0, 0, 1);
    idle("R8", 31);
    step("R11", 31, 1, 70, 71, 2, 1, 1);
    step("R11", 28, 1, 70, 71, 2, 1, 0);
    step("R7", 29, 0, 0, 0, 0, 0, 1);
    step("R2", 29, 1, 90, 92, 1, 0, 0);
    step("R6", 91, 0, 0, 0, 0, 1, 0);
    step("R12", 92, 1, 95, 96, 0, 0, 0);
    idle("R12", 96);
    idle("R12", 97);
    step("R7", 40, 0, 0, 0, 0, 0, 1);
    idle("R1", 40);
    for (int k = 0; k < 4000; k++) begin
      r = int'($urandom_range(0, 99));
      b = (r < 12); co = (r >= 12 && r < 18); br = (r >= 18 && r < 22);
      if (($urandom_range(0, 1) == 1) && m_sp > 0) p = m_top_end();
      else p = AW'($urandom_range(0, 127));
      s = AW'($urandom_range(0, 120));
      step("R11", p, b, s, s + AW'($urandom_range(0, 7)), CW'($urandom_range(0, 4)), co, br);
    end
    finish_run();
  end
endmodule